// File: doc/BRIEF.md
# Serial DAC Setting Interface

This block is the digital front end of a multi-channel voltage setting device. A host drives a serial clock, a chip-select line and a data-in line. Each frame carries a start bit, a channel number and an 8-bit setting. The block keeps one volatile working register per channel, and these registers drive the analog stage. It also receives a nonvolatile shadow copy of every setting from a separate storage sequencer. Every frame reads back at the same time as it writes. While the new setting is shifted in, the value the addressed register held before the frame is shifted out on the data-out line. The block also provides an enable for the data-out line, so an outer pad can tri-state it.

All serial lines are sampled in the system clock domain. The serial clock is brought in through a two-stage synchronizer and then detected on its rising edge. The chip-select line passes through a deglitching filter. A working value written over the serial port only lasts while the chip is selected. When the filtered select drops, every channel is reloaded from the shadow copy, so any trial setting is lost. The same reload takes place during reset, which needs no serial clock.

The frame decoder is an enumerated state machine with these states. IDLE: deselected. HUNT: waiting for a start bit. ADDR: collecting the channel bits. DATA: collecting the setting bits while the old value is shifted out. COMMIT: the working register is written on this serial edge. GAP: a spacing edge in which the decoder accepts nothing. The transitions are these. IDLE goes to HUNT when the filtered select rises. HUNT goes to ADDR on a serial edge that carries a 1. ADDR goes to DATA after the last channel bit. DATA goes to COMMIT after the eighth data bit. COMMIT goes to GAP on the next edge, and GAP goes to HUNT on the edge after that. From any state, the machine returns to IDLE when the filtered select falls.

Top module: `sdac_serial_if`

## Requirements
- R1: While reset is held, and afterwards with no serial clock edge, setting_o equals shadow_i. After reset, sdo_oe_o and sdo_o are 0.
- R2: A frame is a 1 start bit, then the channel bits, then data bits D0 first through D7 last, each taken on a rising serial clock edge. The channel number is {second channel bit, first channel bit}. Channel k occupies setting_o[8k+7:8k].
- R3: In HUNT, a 0 on data-in at a serial rising edge is ignored, so any number of leading zeros may come before the start bit.
- R4: Once the edge that carries the last channel bit has been taken, sdo_o shows bit 0 of the addressed channel's prior working value. Each data edge then advances to the next higher bit, so bit i is valid before data edge i.
- R5: setting_o does not change at the edge that carries D7. The addressed channel takes the new value at the next rising serial edge, and the other channels keep their values.
- R6: Data-in is ignored on the first two rising edges after D7. A start bit is accepted on the third.
- R7: sdo_oe_o follows the filtered select. sdo_o is 0 whenever sdo_oe_o is 0, and while the decoder is outside DATA.
- R8: When the filtered select falls, every channel is reloaded from the shadow_i value present at that moment.
- R9: A low pulse on cs_i shorter than CS_FILT system clock cycles causes no reload, and the temporary settings remain on setting_o.
- R10: Deselecting in the middle of a frame abandons it. After reselection the decoder hunts for a fresh start bit.
- R11: If the commit edge and the falling filtered select land in the same system cycle, the reload wins and setting_o equals shadow_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_i | input | 1 | Chip select, active high |
| sdi_i | input | 1 | Serial data in |
| shadow_i | input | NCH*W | Nonvolatile copy of all settings |
| setting_o | output | NCH*W | Working settings that drive the outputs |
| sdo_o | output | 1 | Serial readback data |
| sdo_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
The serial commit and the deselect reload can both act on the working registers in one system cycle. The bench shifts a complete frame up to D7. It then drops cs_i and raises the commit edge at offsets of zero to seven system cycles from each other, so the synchronizer and filter delays pass through the point where both land together. For every offset the bench expects setting_o to end equal to the shadow value and the output enable to be low, whether the commit came before, with or after the reload.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ADDR,
        ST_DATA,
        ST_COMMIT,
        ST_GAP
    } sdac_state_t;

endpackage

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic cs_i,
    input  logic sdi_i,
    output logic sclk_rise_o,
    output logic cs_o,
    output logic sdi_o
);
    logic [STAGES-1:0][2:0] pipe_q;
    logic                   sclk_prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (!rst_ni) pipe_q[s] <= '0;
                else         pipe_q[s] <= {sdi_i, cs_i, sclk_i};
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (!rst_ni) pipe_q[s] <= '0;
                else         pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sclk_prev_q <= 1'b0;
        else         sclk_prev_q <= pipe_q[STAGES-1][0];
    end

    always_comb begin
        sclk_rise_o = pipe_q[STAGES-1][0] & ~sclk_prev_q;
        cs_o        = pipe_q[STAGES-1][1];
        sdi_o       = pipe_q[STAGES-1][2];
    end

    p_single_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_rise_o |=> !sclk_rise_o);

endmodule

// File: rtl/sdac_cs_filter.sv
module sdac_cs_filter #(
    parameter int CS_FILT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_s_i,
    output logic active_o,
    output logic drop_o
);
    localparam int CW = (CS_FILT > 1) ? $clog2(CS_FILT) : 1;

    logic [CW-1:0] low_cnt_q;
    logic          active_q;
    logic          fall_now;

    always_comb begin
        fall_now = active_q && !cs_s_i && (low_cnt_q == CW'(CS_FILT - 1));
        active_o = active_q;
        drop_o   = fall_now;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_q  <= 1'b0;
            low_cnt_q <= '0;
        end else if (cs_s_i) begin
            active_q  <= 1'b1;
            low_cnt_q <= '0;
        end else if (fall_now) begin
            active_q  <= 1'b0;
            low_cnt_q <= '0;
        end else if (active_q) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    p_select_fast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_s_i |=> active_o);
    p_glitch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && cs_s_i) |=> active_o);

endmodule

// File: rtl/sdac_frame_fsm.sv
module sdac_frame_fsm
    import sdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sel_i,
    input  logic                     rise_i,
    input  logic                     sdi_i,
    input  logic [W-1:0]             rd_word_i,
    output logic [$clog2(NCH)-1:0]   rd_addr_o,
    output logic                     wr_en_o,
    output logic [$clog2(NCH)-1:0]   wr_addr_o,
    output logic [W-1:0]             wr_data_o,
    output logic                     sdo_o
);
    localparam int AW = $clog2(NCH);
    localparam int CW = $clog2(W);

    sdac_state_t   state_q, state_d;
    logic [AW-1:0] addr_q, addr_nxt;
    logic [W-1:0]  data_q, rb_q;
    logic [CW-1:0] cnt_q;
    logic          step;

    assign step     = rise_i && sel_i;
    assign addr_nxt = (addr_q >> 1) | (AW'(sdi_i) << (AW - 1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sel_i) state_d = ST_HUNT;
            ST_HUNT:   if (step && sdi_i) state_d = ST_ADDR;
            ST_ADDR:   if (step && cnt_q == CW'(AW - 1)) state_d = ST_DATA;
            ST_DATA:   if (step && cnt_q == CW'(W - 1)) state_d = ST_COMMIT;
            ST_COMMIT: if (step) state_d = ST_GAP;
            ST_GAP:    if (step) state_d = ST_HUNT;
            default:   state_d = ST_IDLE;
        endcase
        if (!sel_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            rb_q   <= '0;
        end else if (step) begin
            unique case (state_q)
                ST_HUNT: cnt_q <= '0;
                ST_ADDR: begin
                    addr_q <= addr_nxt;
                    if (cnt_q == CW'(AW - 1)) begin
                        cnt_q <= '0;
                        rb_q  <= rd_word_i;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    data_q <= {sdi_i, data_q[W-1:1]};
                    rb_q   <= rb_q >> 1;
                    cnt_q  <= cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        rd_addr_o = addr_nxt;
        wr_en_o   = step && (state_q == ST_COMMIT);
        wr_addr_o = addr_q;
        wr_data_o = data_q;
        sdo_o     = sel_i && (state_q == ST_DATA) && rb_q[0];
    end

    p_deselect_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> state_q == ST_IDLE);
    p_gap_follows_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_GAP && $past(state_q) != ST_GAP) |-> $past(state_q) == ST_COMMIT);
    p_write_needs_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> sel_i && rise_i);

endmodule

// File: rtl/sdac_setting_bank.sv
module sdac_setting_bank #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   reload_i,
    input  logic [NCH*W-1:0]       shadow_i,
    input  logic                   wr_en_i,
    input  logic [$clog2(NCH)-1:0] wr_addr_i,
    input  logic [W-1:0]           wr_data_i,
    input  logic [$clog2(NCH)-1:0] rd_addr_i,
    output logic [W-1:0]           rd_word_o,
    output logic [NCH*W-1:0]       setting_o
);
    logic [NCH-1:0][W-1:0] work_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk_i) begin
            if (!rst_ni || reload_i)
                work_q[c] <= shadow_i[c*W +: W];
            else if (wr_en_i && wr_addr_i == c)
                work_q[c] <= wr_data_i;
        end
        assign setting_o[c*W +: W] = work_q[c];
    end

    assign rd_word_o = work_q[rd_addr_i];

    p_reload_restores_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_i |=> setting_o == $past(shadow_i));
    p_reload_beats_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i && wr_en_i) |=> setting_o == $past(shadow_i));
    p_hold_without_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!reload_i && !wr_en_i) |=> $stable(setting_o));

endmodule

// File: rtl/sdac_serial_if.sv
module sdac_serial_if #(
    parameter int NCH     = 4,
    parameter int W       = 8,
    parameter int SYNC    = 2,
    parameter int CS_FILT = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sclk_i,
    input  logic             cs_i,
    input  logic             sdi_i,
    input  logic [NCH*W-1:0] shadow_i,
    output logic [NCH*W-1:0] setting_o,
    output logic             sdo_o,
    output logic             sdo_oe_o
);
    localparam int AW = $clog2(NCH);

    logic          rise, cs_s, sdi_s, sel, drop, wr_en, sdo_raw;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [W-1:0]  rd_word, wr_data;

    sdac_in_sync #(.STAGES(SYNC)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_i(cs_i),
        .sdi_i(sdi_i), .sclk_rise_o(rise), .cs_o(cs_s), .sdi_o(sdi_s)
    );

    sdac_cs_filter #(.CS_FILT(CS_FILT)) u_filt (
        .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s),
        .active_o(sel), .drop_o(drop)
    );

    sdac_frame_fsm #(.NCH(NCH), .W(W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .rise_i(rise),
        .sdi_i(sdi_s), .rd_word_i(rd_word), .rd_addr_o(rd_addr),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .sdo_o(sdo_raw)
    );

    sdac_setting_bank #(.NCH(NCH), .W(W)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(drop), .shadow_i(shadow_i),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_word_o(rd_word), .setting_o(setting_o)
    );

    always_comb begin
        sdo_oe_o = sel;
        sdo_o    = sel & sdo_raw;
    end

    p_sdo_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sdo_oe_o |-> !sdo_o);
    p_reset_state_r1: assert property (@(posedge clk_i)
        !rst_ni |=> setting_o == $past(shadow_i));

endmodule

// File: tb/sdac_serial_if_tb_top.sv
`timescale 1ns/1ps
module sdac_serial_if_tb_top;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs = 1'b0, sdi = 1'b0;
    logic [31:0] shadow;
    logic [31:0] setting;
    logic        sdo, sdo_oe;
    logic [31:0] mdl;
    int          n_vec = 0, n_bad = 0;

    localparam logic [31:0] SH0 = 32'hC35A_8117;
    localparam logic [31:0] SH1 = 32'h29E4_6BD0;

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] val;
        logic [3:0] lead;
        logic       gdi;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 8'hA5, 4'd0, 1'b0},
        '{2'd1, 8'h3C, 4'd3, 1'b1},
        '{2'd2, 8'hFF, 4'd0, 1'b1},
        '{2'd3, 8'h00, 4'd5, 1'b0},
        '{2'd0, 8'h5E, 4'd1, 1'b1},
        '{2'd2, 8'h81, 4'd0, 1'b0},
        '{2'd3, 8'h7F, 4'd2, 1'b1},
        '{2'd1, 8'h01, 4'd0, 1'b1}
    };

    always #2.5 clk = ~clk;

    sdac_serial_if dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .sdi_i(sdi),
        .shadow_i(shadow), .setting_o(setting), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        sdi = b; tick(H);
        sclk = 1'b1; tick(H);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [1:0] ch, input logic [7:0] v, input int lead,
                        input logic gdi, output logic [7:0] rb,
                        output logic [31:0] at_d7, output logic [31:0] at_commit);
        for (int k = 0; k < lead; k++) pulse(1'b0);
        pulse(1'b1);
        pulse(ch[0]);
        pulse(ch[1]);
        for (int i = 0; i < 8; i++) begin
            sdi = v[i]; tick(H);
            rb[i] = sdo;
            sclk = 1'b1; tick(H);
            sclk = 1'b0;
        end
        at_d7 = setting;
        pulse(gdi);
        at_commit = setting;
        pulse(gdi);
    endtask

    function automatic logic [31:0] put(input logic [31:0] m, input logic [1:0] ch,
                                        input logic [7:0] v);
        logic [31:0] r = m;
        r[ch*8 +: 8] = v;
        return r;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]  rb;
        logic [31:0] s7, sc;
        shadow = SH0;
        tick(5);
        // R1: reset loads shadow, outputs quiet
        chk("R1 setting in reset", setting, SH0);
        rst_n = 1'b1;
        tick(10);
        chk("R1 setting after reset", setting, SH0);
        chk("R1 oe after reset", {31'd0, sdo_oe}, 32'd0);
        chk("R1 sdo after reset", {31'd0, sdo}, 32'd0);

        // R7: enable follows select
        cs = 1'b1; tick(10);
        chk("R7 oe with select", {31'd0, sdo_oe}, 32'd1);
        chk("R7 sdo idle in hunt", {31'd0, sdo}, 32'd0);

        // Vector table: R2 R3 R4 R5 R6
        mdl = SH0;
        foreach (VEC[j]) begin
            send(VEC[j].ch, VEC[j].val, int'(VEC[j].lead), VEC[j].gdi, rb, s7, sc);
            chk("R4 readback", {24'd0, rb}, {24'd0, mdl[VEC[j].ch*8 +: 8]});
            chk("R5 unchanged at D7", s7, mdl);
            mdl = put(mdl, VEC[j].ch, VEC[j].val);
            chk("R2 commit value", sc, mdl);
            tick(4);
            chk("R6 gap edges ignored", setting, mdl);
        end

        // R9: short glitch keeps temporary values
        cs = 1'b0; tick(2); cs = 1'b1; tick(12);
        chk("R9 no reload on glitch", setting, mdl);
        chk("R9 still enabled", {31'd0, sdo_oe}, 32'd1);
        send(2'd1, 8'hC7, 0, 1'b0, rb, s7, sc);
        chk("R9 frame after glitch readback", {24'd0, rb}, {24'd0, mdl[15:8]});
        mdl = put(mdl, 2'd1, 8'hC7);
        chk("R9 frame after glitch commit", sc, mdl);

        // R8: deselect reloads from current shadow
        shadow = SH1;
        cs = 1'b0; tick(12);
        chk("R8 reload from shadow", setting, SH1);
        chk("R7 oe off after deselect", {31'd0, sdo_oe}, 32'd0);
        chk("R7 sdo off after deselect", {31'd0, sdo}, 32'd0);
        mdl = SH1;

        // R10: abort mid-frame, then fresh frame
        cs = 1'b1; tick(10);
        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        cs = 1'b0; tick(12);
        chk("R10 abort no write", setting, mdl);
        cs = 1'b1; tick(10);
        send(2'd2, 8'h96, 1, 1'b0, rb, s7, sc);
        chk("R10 fresh frame readback", {24'd0, rb}, {24'd0, mdl[23:16]});
        mdl = put(mdl, 2'd2, 8'h96);
        chk("R10 fresh frame commit", sc, mdl);
        cs = 1'b0; tick(12);
        mdl = SH1;

        // R11: commit edge swept across the reload
        for (int off = 0; off < 8; off++) begin
            cs = 1'b1; tick(10);
            pulse(1'b1); pulse(1'b0); pulse(1'b1);
            for (int i = 0; i < 8; i++) pulse(off[i % 3]);
            sdi = 1'b0; tick(H);
            cs = 1'b0;
            tick(off);
            sclk = 1'b1; tick(H);
            sclk = 1'b0; tick(20);
            chk($sformatf("R11 offset %0d setting", off), setting, SH1);
            chk($sformatf("R11 offset %0d oe", off), {31'd0, sdo_oe}, 32'd0);
        end

        finish_run();
    end

endmodule